// File: doc/BRIEF.md
# Single-Channel DMA Engine with Selectable Bus Sharing

This block copies a run of bytes from one region of a shared synchronous memory to another, on behalf of software, while a CPU competes for the same bus. Software writes a source byte address, a destination byte address and a byte length into small configuration registers. A write to the control register then starts the copy and picks how the engine shares the bus with the CPU. Addresses are taken as word-aligned: the low address bits that select a byte inside a word are dropped. Data moves one whole memory word at a time. Each word costs one read cycle and one write cycle. When the length is not a whole number of words, byte-lane strobes protect the unused bytes of the last destination word.

Three sharing policies are offered:
- **Burst**: the engine keeps the bus for the whole copy.
- **Steal**: the engine never uses two bus cycles in a row.
- **Idle-only**: the CPU always wins, so a busy CPU can stall the copy indefinitely.

The CPU asks for the bus on a request line and is answered on a grant line. When the copy ends, a completion flag and an interrupt line are raised. Software can poll the flag or take the interrupt. Software clears the interrupt through a status write.

Top module: `dmae_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `irq_o` and `mem_en` are low, and `cpu_gnt` equals `cpu_req`.
- R2: Register map on `cfg_addr`: 0 source byte address, 1 destination byte address, 2 length in bytes, 3 control (bit 0 start, bits 2:1 policy), 4 status (writing bit 0 = 1 clears the interrupt). The word address on `mem_addr` is the byte address shifted right by log2(DW/8). For each word the engine reads the source word, then writes it unchanged to the destination word, and both pointers advance by one word. A read has `mem_we` low and `mem_be` all zero. Read data is returned one cycle after the read.
- R3: Policy 00 (burst): engine bus cycles fall on consecutive cycles. A copy of N bytes keeps `busy_o` high for exactly 2*ceil(N/4) cycles. `cpu_gnt` stays low while `busy_o` is high, even with `cpu_req` high.
- R4: Policy 01 (steal): the engine never drives `mem_en` in two consecutive cycles. While busy, a requesting CPU is granted in every cycle the engine does not use. With `cpu_req` held high, a copy of N bytes keeps `busy_o` high for 4*ceil(N/4)-1 cycles.
- R5: Policy 10 (idle-only): while `cpu_req` is high, `cpu_gnt` is high and `mem_en` is low. The engine makes progress only in cycles with `cpu_req` low.
- R6: On a destination write, strobe bit i (bytes 8i+7:8i of the word) is set exactly when more than i bytes remain. A final partial word therefore writes only its low lanes, and the other lanes keep their old contents.
- R7: `done_o` and `irq_o` rise on the clock edge that ends the final write. `busy_o` falls on that same edge.
- R8: Writing 1 to status bit 0 clears `irq_o` but leaves `done_o` set. `done_o` is cleared by the next start of a nonzero-length copy.
- R9: While `busy_o` is high, writes to the address, length and control registers are ignored. A start written during a copy neither restarts it nor changes its policy or parameters.
- R10: A start with length zero sets `done_o` and `irq_o` on the edge of the start write, without raising `busy_o` or `mem_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cpu_req | input | 1 | CPU asks for the bus this cycle |
| cpu_gnt | output | 1 | CPU owns the bus this cycle |
| mem_en | output | 1 | Engine uses the bus this cycle |
| mem_we | output | 1 | Engine access is a write |
| mem_addr | output | AW | Word address |
| mem_be | output | DW/8 | Byte-lane write strobes |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after a read |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | Completion flag for polling |
| irq_o | output | 1 | Completion interrupt |

## Verification
A copy starts on the edge that captures the control write, so its first bus cycle is the very next cycle. The bench begins its per-transfer cycle counters just before that write and samples every output on the falling edge, half a cycle after the edge that caused it. The busy-cycle counts of R3 and R4 are therefore exact figures, not bounds. Completion flags are read at the first falling edge after `busy_o` drops. For a zero-length start they are read at the first falling edge after the write edge. Copied data is compared against values the bench computes itself. Policy rules (no back-to-back engine cycles, no grant during a burst, yielding to a requesting CPU) are tallied on every falling edge.

// File: rtl/dmae_pkg.sv
package dmae_pkg;
   typedef enum logic [1:0] {
      POL_BURST = 2'b00,
      POL_STEAL = 2'b01,
      POL_IDLE  = 2'b10,
      POL_RSVD  = 2'b11
   } policy_e;

   typedef enum logic [1:0] {
      MV_IDLE = 2'b00,
      MV_RD   = 2'b01,
      MV_WR   = 2'b10
   } mover_st_e;

   localparam logic [2:0] REG_SRC  = 3'd0;
   localparam logic [2:0] REG_DST  = 3'd1;
   localparam logic [2:0] REG_LEN  = 3'd2;
   localparam logic [2:0] REG_CTRL = 3'd3;
   localparam logic [2:0] REG_STAT = 3'd4;
endpackage

// File: rtl/dmae_regs.sv
module dmae_regs
   import dmae_pkg::*;
#(
   parameter int unsigned AW  = 16,
   parameter int unsigned LW  = 16,
   parameter int unsigned OFS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [2:0]    cfg_addr,
   input  logic [31:0]   cfg_wdata,
   input  logic          busy,
   input  logic          finish,
   output logic [AW-1:0] src_word,
   output logic [AW-1:0] dst_word,
   output logic [LW-1:0] len,
   output policy_e       mode,
   output logic          start,
   output logic          done,
   output logic          irq
);
   logic          start_hit;
   logic          clr_hit;
   logic [AW-1:0] src_q, dst_q;
   logic [LW-1:0] len_q;
   policy_e       mode_q;
   logic          done_q, irq_q;

   assign start_hit = cfg_we && !busy && (cfg_addr == REG_CTRL) && cfg_wdata[0];
   assign clr_hit   = cfg_we && (cfg_addr == REG_STAT) && cfg_wdata[0];
   assign start     = start_hit && (len_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         len_q  <= '0;
         mode_q <= POL_BURST;
         done_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (cfg_we && !busy) begin
            case (cfg_addr)
               REG_SRC:  src_q  <= cfg_wdata[OFS +: AW];
               REG_DST:  dst_q  <= cfg_wdata[OFS +: AW];
               REG_LEN:  len_q  <= cfg_wdata[LW-1:0];
               REG_CTRL: mode_q <= policy_e'(cfg_wdata[2:1]);
               default: ;
            endcase
         end
         if (clr_hit) irq_q <= 1'b0;
         if (start_hit) begin
            if (len_q == '0) begin
               done_q <= 1'b1;
               irq_q  <= 1'b1;
            end else begin
               done_q <= 1'b0;
            end
         end
         if (finish) begin
            done_q <= 1'b1;
            irq_q  <= 1'b1;
         end
      end
   end

   assign src_word = src_q;
   assign dst_word = dst_q;
   assign len      = len_q;
   assign mode     = mode_q;
   assign done     = done_q;
   assign irq      = irq_q;

   // R9: parameters and policy cannot change under a running copy
   p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_we) |=> ($stable(len_q) && $stable(mode_q) && $stable(src_q)));

   // R10: zero length completes at once with no copy started
   p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_hit && len_q == '0) |=> (done_q && irq_q && !busy));
endmodule

// File: rtl/dmae_arb.sv
module dmae_arb
   import dmae_pkg::*;
#(
   parameter int unsigned STEAL_GAP = 1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  policy_e mode,
   input  logic    busy,
   input  logic    want,
   input  logic    cpu_req,
   output logic    go,
   output logic    cpu_gnt
);
   logic gap_ok;

   generate
      if (STEAL_GAP == 1) begin : g_flag
         logic last_q;
         always_ff @(posedge clk) begin
            if (!rst_n) last_q <= 1'b0;
            else        last_q <= go;
         end
         assign gap_ok = !last_q;
      end else begin : g_cnt
         localparam int unsigned GW = $clog2(STEAL_GAP + 1);
         logic [GW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)            cnt_q <= '0;
            else if (go)           cnt_q <= GW'(STEAL_GAP);
            else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         end
         assign gap_ok = (cnt_q == '0);
      end
   endgenerate

   always_comb begin
      case (mode)
         POL_STEAL: begin
            go      = busy && want && gap_ok;
            cpu_gnt = cpu_req && !go;
         end
         POL_IDLE: begin
            go      = busy && want && !cpu_req;
            cpu_gnt = cpu_req;
         end
         default: begin
            go      = busy && want;
            cpu_gnt = cpu_req && !busy;
         end
      endcase
   end

   // R2: the bus has one owner per cycle
   p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(go && cpu_gnt));
endmodule

// File: rtl/dmae_mover.sv
module dmae_mover
   import dmae_pkg::*;
#(
   parameter int unsigned AW = 16,
   parameter int unsigned LW = 16,
   parameter int unsigned DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [AW-1:0]   src_word,
   input  logic [AW-1:0]   dst_word,
   input  logic [LW-1:0]   len,
   input  logic            go,
   input  logic [DW-1:0]   mem_rdata,
   output logic            busy,
   output logic            want,
   output logic            finish,
   output logic            mem_en,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW/8-1:0] mem_be,
   output logic [DW-1:0]   mem_wdata
);
   localparam int unsigned LANES = DW / 8;

   mover_st_e     st_q;
   logic [AW-1:0] sp_q, dp_q;
   logic [LW-1:0] rem_q;
   logic [DW-1:0] buf_q;
   logic          fresh_q;
   logic          last_word;

   assign busy      = (st_q != MV_IDLE);
   assign want      = busy;
   assign last_word = (rem_q <= LW'(LANES));
   assign mem_en    = go;
   assign mem_we    = (st_q == MV_WR);
   assign mem_addr  = (st_q == MV_WR) ? dp_q : sp_q;
   assign mem_wdata = fresh_q ? mem_rdata : buf_q;
   assign finish    = go && (st_q == MV_WR) && last_word;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign mem_be[i] = (st_q == MV_WR) && (rem_q > LW'(i));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= MV_IDLE;
         sp_q    <= '0;
         dp_q    <= '0;
         rem_q   <= '0;
         buf_q   <= '0;
         fresh_q <= 1'b0;
      end else begin
         fresh_q <= go && (st_q == MV_RD);
         if (fresh_q) buf_q <= mem_rdata;
         case (st_q)
            MV_IDLE: if (start) begin
               sp_q  <= src_word;
               dp_q  <= dst_word;
               rem_q <= len;
               st_q  <= MV_RD;
            end
            MV_RD: if (go) begin
               sp_q <= sp_q + 1'b1;
               st_q <= MV_WR;
            end
            MV_WR: if (go) begin
               dp_q <= dp_q + 1'b1;
               if (last_word) begin
                  rem_q <= '0;
                  st_q  <= MV_IDLE;
               end else begin
                  rem_q <= rem_q - LW'(LANES);
                  st_q  <= MV_RD;
               end
            end
            default: st_q <= MV_IDLE;
         endcase
      end
   end

   // R6: every destination write carries at least the lowest lane
   p_be_low_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> mem_be[0]);

   // R2: a write is always preceded by its read
   p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && !mem_we) |=> (busy && mem_we));
endmodule

// File: rtl/dmae_top.sv
module dmae_top
   import dmae_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned LW        = 16,
   parameter int unsigned DW        = 32,
   parameter int unsigned STEAL_GAP = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [2:0]      cfg_addr,
   input  logic [31:0]     cfg_wdata,
   input  logic            cpu_req,
   output logic            cpu_gnt,
   output logic            mem_en,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW/8-1:0] mem_be,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata,
   output logic            busy_o,
   output logic            done_o,
   output logic            irq_o
);
   localparam int unsigned OFS = $clog2(DW / 8);

   generate
      if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
         $error("DW must be a nonzero multiple of 8");
      end
      if (OFS + AW > 32 || LW > 32 || LW <= OFS) begin : g_bad_aw
         $error("address or length width does not fit the register bus");
      end
      if (STEAL_GAP < 1) begin : g_bad_gap
         $error("STEAL_GAP must be at least 1");
      end
   endgenerate

   logic [AW-1:0] src_word, dst_word;
   logic [LW-1:0] len;
   policy_e       mode;
   logic          start, finish, busy, want, go;

   dmae_regs #(.AW(AW), .LW(LW), .OFS(OFS)) u_regs (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
      .busy, .finish, .src_word, .dst_word, .len, .mode,
      .start, .done(done_o), .irq(irq_o)
   );

   dmae_arb #(.STEAL_GAP(STEAL_GAP)) u_arb (
      .clk, .rst_n, .mode, .busy, .want, .cpu_req, .go, .cpu_gnt
   );

   dmae_mover #(.AW(AW), .LW(LW), .DW(DW)) u_mover (
      .clk, .rst_n, .start, .src_word, .dst_word, .len, .go, .mem_rdata,
      .busy, .want, .finish, .mem_en, .mem_we, .mem_addr, .mem_be, .mem_wdata
   );

   assign busy_o = busy;

   // R3: no CPU grant during a burst copy
   p_burst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && mode == POL_BURST) |-> !cpu_gnt);

   // R4: stolen cycles are never adjacent
   p_steal_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == POL_STEAL && mem_en) |=> !mem_en);

   // R5: a requesting CPU always wins in idle-only policy
   p_idle_yield_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == POL_IDLE && cpu_req) |-> (!mem_en && cpu_gnt));

   // R7: completion is only flagged once the engine is idle
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
endmodule

// File: tb/sim_dmae_top.sv
module sim_dmae_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        cpu_req = 1'b0;
   logic        cpu_gnt, mem_en, mem_we, busy_o, done_o, irq_o;
   logic [15:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;

   logic [31:0] mem [0:63];

   int checks = 0, errors = 0;
   int busy_cyc, eng_cyc, back2back, gnt_busy, gnt_missing, yield_bad;
   logic [3:0] last_be;
   logic prev_en = 1'b0;
   int cur_mode = 0;

   always #5 clk = ~clk;

   dmae_top u0 (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cpu_req, .cpu_gnt,
      .mem_en, .mem_we, .mem_addr, .mem_be, .mem_wdata, .mem_rdata,
      .busy_o, .done_o, .irq_o
   );

   // synchronous memory model: read data one cycle after the read
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            for (int i = 0; i < 4; i++)
               if (mem_be[i]) mem[mem_addr[5:0]][8*i +: 8] <= mem_wdata[8*i +: 8];
         end else begin
            mem_rdata <= mem[mem_addr[5:0]];
         end
      end
   end

   // per-cycle monitor, away from the active edge
   always @(negedge clk) begin
      if (busy_o) busy_cyc++;
      if (busy_o && cpu_gnt) gnt_busy++;
      if (busy_o && cpu_req && !mem_en && !cpu_gnt) gnt_missing++;
      if (mem_en) begin
         eng_cyc++;
         if (prev_en) back2back++;
         if (cur_mode == 2 && cpu_req) yield_bad++;
         if (mem_we) last_be = mem_be;
      end
      prev_en = mem_en;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int w);
      return (32'(w) * 32'h01030507) ^ 32'h5A3C0F00;
   endfunction

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); #1;
      cfg_we = 1'b0;
   endtask

   task automatic clr_counts();
      busy_cyc = 0; eng_cyc = 0; back2back = 0; gnt_busy = 0;
      gnt_missing = 0; yield_bad = 0; last_be = 4'hx;
   endtask

   task automatic fill(input int base, input int n, input logic [31:0] v);
      @(posedge clk); #1;
      for (int w = 0; w < n; w++) mem[base + w] <= v;
      @(posedge clk); #1;
   endtask

   task automatic start_xfer(input int srcw, input int dstw, input int len, input int mode);
      wr(3'd0, 32'(srcw * 4));
      wr(3'd1, 32'(dstw * 4));
      wr(3'd2, 32'(len));
      clr_counts();
      cur_mode = mode;
      wr(3'd3, 32'((mode << 1) | 1));
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 500; k++) begin
         @(negedge clk);
         if (!busy_o) break;
      end
   endtask

   task automatic check_copy(input string tag, input int srcw, input int dstw,
                             input int len, input logic [31:0] fillv);
      int nw;
      logic [31:0] exp;
      nw = (len + 3) / 4;
      for (int w = 0; w < nw; w++) begin
         exp = fillv;
         for (int b = 0; b < 4; b++)
            if (w * 4 + b < len) exp[8*b +: 8] = pat(srcw + w)[8*b +: 8];
         chk(tag, mem[dstw + w], exp);
      end
      chk({tag, " untouched"}, mem[dstw + nw], fillv);
   endtask

   task automatic t_reset();
      cpu_req = 1'b1;
      @(negedge clk);
      chk("R1 busy", 32'(busy_o), 0);
      chk("R1 done", 32'(done_o), 0);
      chk("R1 irq", 32'(irq_o), 0);
      chk("R1 mem_en", 32'(mem_en), 0);
      chk("R1 cpu_gnt", 32'(cpu_gnt), 1);
   endtask

   task automatic t_burst();
      fill(32, 8, 32'hEEEE_EEEE);
      cpu_req = 1'b1;
      start_xfer(0, 32, 16, 0);
      wait_idle();
      chk("R3 busy cycles", 32'(busy_cyc), 8);
      chk("R3 grant during burst", 32'(gnt_busy), 0);
      chk("R3 back-to-back", 32'(back2back), 7);
      chk("R7 done", 32'(done_o), 1);
      chk("R7 irq", 32'(irq_o), 1);
      check_copy("R2 burst data", 0, 32, 16, 32'hEEEE_EEEE);
      wr(3'd4, 32'h1);
      @(negedge clk);
      chk("R8 irq cleared", 32'(irq_o), 0);
      chk("R8 done kept", 32'(done_o), 1);
   endtask

   task automatic t_steal();
      fill(40, 8, 32'h1111_1111);
      cpu_req = 1'b1;
      start_xfer(4, 40, 12, 1);
      @(negedge clk);
      chk("R8 done cleared by start", 32'(done_o), 0);
      wait_idle();
      chk("R4 busy cycles", 32'(busy_cyc), 11);
      chk("R4 engine cycles", 32'(eng_cyc), 6);
      chk("R4 adjacent engine cycles", 32'(back2back), 0);
      chk("R4 cpu starved", 32'(gnt_missing), 0);
      check_copy("R2 steal data", 4, 40, 12, 32'h1111_1111);
   endtask

   task automatic t_idle();
      fill(48, 8, 32'h2222_2222);
      cpu_req = 1'b1;
      start_xfer(8, 48, 8, 2);
      repeat (20) @(negedge clk);
      chk("R5 no progress while cpu busy", 32'(eng_cyc), 0);
      chk("R5 still busy", 32'(busy_o), 1);
      chk("R5 cpu granted", 32'(cpu_gnt), 1);
      @(posedge clk); #1;
      cpu_req = 1'b0;
      wait_idle();
      chk("R5 engine cycles", 32'(eng_cyc), 4);
      chk("R5 yield violations", 32'(yield_bad), 0);
      check_copy("R5 idle data", 8, 48, 8, 32'h2222_2222);
   endtask

   task automatic t_frozen();
      fill(32, 8, 32'h3333_3333);
      cpu_req = 1'b1;
      start_xfer(0, 32, 16, 2);
      wr(3'd0, 32'(16 * 4));
      wr(3'd2, 32'd4);
      wr(3'd3, 32'h1);
      repeat (4) @(negedge clk);
      chk("R9 policy kept", 32'(eng_cyc), 0);
      @(posedge clk); #1;
      cpu_req = 1'b0;
      wait_idle();
      chk("R9 length kept", 32'(eng_cyc), 8);
      check_copy("R9 source kept", 0, 32, 16, 32'h3333_3333);
   endtask

   task automatic t_partial();
      fill(32, 8, 32'hFFFF_FFFF);
      cpu_req = 1'b0;
      start_xfer(0, 32, 7, 0);
      wait_idle();
      chk("R6 strobes 7 bytes", 32'(last_be), 32'h7);
      check_copy("R6 partial data", 0, 32, 7, 32'hFFFF_FFFF);
      fill(40, 4, 32'hFFFF_FFFF);
      start_xfer(2, 40, 1, 0);
      wait_idle();
      chk("R6 strobes 1 byte", 32'(last_be), 32'h1);
      chk("R6 one byte cycles", 32'(eng_cyc), 2);
      check_copy("R6 single byte", 2, 40, 1, 32'hFFFF_FFFF);
   endtask

   task automatic t_zero();
      wr(3'd4, 32'h1);
      @(negedge clk);
      chk("R8 irq cleared before zero", 32'(irq_o), 0);
      wr(3'd2, 32'd0);
      clr_counts();
      wr(3'd3, 32'h1);
      @(negedge clk);
      chk("R10 done", 32'(done_o), 1);
      chk("R10 irq", 32'(irq_o), 1);
      chk("R10 busy", 32'(busy_o), 0);
      repeat (3) @(negedge clk);
      chk("R10 no bus activity", 32'(eng_cyc), 0);
   endtask

   initial begin
      for (int w = 0; w < 64; w++) mem[w] = pat(w);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_burst();
      t_steal();
      t_idle();
      t_frozen();
      t_partial();
      t_zero();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (R1..all): act=timeout exp=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule